// File: doc/BRIEF.md
# Serial Ethernet CRC-32 Generator with Selectable Register Structure

This block computes the 32-bit frame check sequence of an Ethernet frame one bit per clock. Bits arrive in transmission order, which is the least significant bit of each octet first. A valid strobe qualifies each bit. A start strobe marks the first bit of a frame and an end strobe marks the last bit. When the remainder is final, the block raises a one-cycle done flag and presents the complemented remainder as the FCS.

A parameter selects one of two register structures, and both produce identical results. The first structure multiplies by x^32 and divides in the same step. It is preset to all ones and finishes on the last data bit. The second structure divides only. It starts from zero, complements the first 32 bits that enter it, and then shifts in 32 zero bits to supply the multiplication, so it finishes 32 cycles later.

Neither structure ever steers the register away from the all-zero state. Zero is a legal intermediate remainder, and the register simply keeps evolving from it.

Top module: `crc32_serial_gen`

## Requirements
- R1: During and after reset, before any frame has been accepted, fcsDone is 0 and fcsOut is 0xFFFFFFFF.
- R2: fcsOut is the bitwise complement of the remainder of division by polynomial 0x04C11DB7. fcsOut[31] is the coefficient of x^31 and is the first FCS bit on the wire. The nine ASCII octets "123456789" give fcsOut = 0x649C2FD3.
- R3: With ARCH = ARCH_SMD, fcsDone is high, and fcsOut holds the final value, in the cycle that directly follows the clock edge that accepts the end-of-frame bit.
- R4: With ARCH = ARCH_DIV, fcsDone rises exactly 32 cycles later than in R3, after 32 zero bits have been shifted in.
- R5: Both architectures produce the same fcsOut for any frame length, including frames shorter than 32 bits. In the divide-only structure, the inversion covers the first 32 bits entering the register, and this count includes flush zeros.
- R6: An all-zero remainder is kept and processed normally. A frame of four 0xFF octets gives fcsOut = 0xFFFFFFFF, and frames that pass through zero mid-frame still give the standard FCS.
- R7: If a frame is followed by its own FCS, sent fcsOut[31] first, the result is fcsOut = 0x38FB2284, which corresponds to residue 0xC704DD7B.
- R8: A start strobe on an accepted bit re-initialises the register and the inversion count in that same cycle, discarding any unfinished frame. The strobed bit becomes the first bit of the new frame.
- R9: Cycles with bitValid low are ignored, whatever sofIn, eofIn and bitIn carry. Valid bits outside a frame without a start strobe are also ignored. In both cases fcsOut is unchanged and fcsDone stays low.
- R10: With ARCH = ARCH_DIV, all input, including start strobes, is ignored during the 32 flush cycles. The pending FCS and its timing are unaffected.
- R11: A bit that carries both sofIn and eofIn forms a complete one-bit frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | Qualifies bitIn, sofIn and eofIn |
| bitIn | input | 1 | Serial data bit in transmission order |
| sofIn | input | 1 | Marks the first bit of a frame |
| eofIn | input | 1 | Marks the last bit of a frame |
| fcsOut | output | CRC_W | Complemented remainder; bit 31 is sent first |
| fcsDone | output | 1 | One-cycle pulse when fcsOut is final |

## Verification
The bench builds two copies side by side from the same stimulus, both with the default 32-bit width and polynomial. One copy uses ARCH_SMD and the other uses ARCH_DIV. This makes it possible to compare the two structures directly, including on frames shorter than the 32-bit inversion window. It also exposes their 32-cycle difference in completion time and shows whether flush-time input is ignored. Each result is also compared with a bit-serial reflected reference model, with fixed known values, and with the self-check residue.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

  // Register structure: multiply-and-divide or divide-only
  typedef enum logic {
    ARCH_SMD = 1'b0,
    ARCH_DIV = 1'b1
  } crcArch_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;    // re-initialise register with this bit
    logic shift;    // advance register by one bit
    logic useZero;  // feed a zero instead of bitIn (flush)
    logic invert;   // complement the bit entering the register
  } crcStrb_t;

endpackage

// File: rtl/crc32_ctrl.sv
module crc32_ctrl
  import crc32_pkg::*;
#(
  parameter crcArch_e ARCH  = ARCH_SMD,
  parameter int       CRC_W = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitValid,
  input  logic     sofIn,
  input  logic     eofIn,
  output crcStrb_t strb,
  output logic     fcsDone
);

  localparam int CNT_W     = $clog2(CRC_W + 1);
  localparam int FLUSH_LEN = CRC_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_FLUSH
  } ctrlState_e;

  ctrlState_e       state, stateNxt;
  logic [CNT_W-1:0] invCnt, invBase, flushCnt;
  logic             accept, lastBit, flushDone, doneNxt;

  always_comb begin
    accept    = bitValid && (state != ST_FLUSH) && (sofIn || state == ST_FRAME);
    lastBit   = accept && eofIn;
    invBase   = (accept && sofIn) ? '0 : invCnt;
    flushDone = (state == ST_FLUSH) && (flushCnt == CNT_W'(FLUSH_LEN - 1));

    strb.start   = accept && sofIn;
    strb.shift   = accept || (state == ST_FLUSH);
    strb.useZero = (state == ST_FLUSH);
    strb.invert  = (ARCH == ARCH_DIV) && (invBase < CNT_W'(CRC_W));
  end

  always_comb begin
    stateNxt = state;
    doneNxt  = 1'b0;
    case (state)
      ST_FLUSH: begin
        if (flushDone) begin
          stateNxt = ST_IDLE;
          doneNxt  = 1'b1;
        end
      end
      default: begin
        if (lastBit) begin
          if (ARCH == ARCH_DIV) begin
            stateNxt = ST_FLUSH;
          end else begin
            stateNxt = ST_IDLE;
            doneNxt  = 1'b1;
          end
        end else if (strb.start) begin
          stateNxt = ST_FRAME;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      invCnt   <= '0;
      flushCnt <= '0;
      fcsDone  <= 1'b0;
    end else begin
      state   <= stateNxt;
      fcsDone <= doneNxt;
      if (strb.shift) begin
        invCnt <= (invBase == CNT_W'(CRC_W)) ? invBase : invBase + CNT_W'(1);
      end
      flushCnt <= (state == ST_FLUSH) ? flushCnt + CNT_W'(1) : '0;
    end
  end

  generate
    if (ARCH == ARCH_SMD) begin : g_smdChk
      AST_SMD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
        lastBit |=> fcsDone); // R3
    end else begin : g_divChk
      AST_DIV_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
        lastBit |=> !fcsDone); // R4
      AST_DIV_DONE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
        fcsDone |-> ($past(state) == ST_FLUSH)); // R4
      AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (state == ST_FLUSH && !flushDone) |=> (state == ST_FLUSH)); // R10
    end
  endgenerate

endmodule

// File: rtl/crc32_dp.sv
module crc32_dp
  import crc32_pkg::*;
#(
  parameter crcArch_e         ARCH  = ARCH_SMD,
  parameter int               CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  crcStrb_t         strb,
  output logic [CRC_W-1:0] crcReg
);

  logic [CRC_W-1:0] crcNxt;

  generate
    if (ARCH == ARCH_SMD) begin : g_smd
      logic [CRC_W-1:0] base;
      logic             fb;
      always_comb begin
        base   = strb.start ? '1 : crcReg;
        fb     = bitIn ^ base[CRC_W-1];
        crcNxt = {base[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end

      AST_SMD_NO_INVERT: assert property (@(posedge clk) disable iff (!rstN)
        !(strb.invert || strb.useZero)); // R5
      AST_ZERO_KEPT_SMD: assert property (@(posedge clk) disable iff (!rstN)
        (strb.shift && !strb.start && crcReg == '0 && !bitIn) |=> (crcReg == '0)); // R6
    end else begin : g_div
      logic [CRC_W-1:0] base;
      logic             dIn;
      always_comb begin
        base   = strb.start ? '0 : crcReg;
        dIn    = (strb.useZero ? 1'b0 : bitIn) ^ strb.invert;
        crcNxt = {base[CRC_W-2:0], dIn} ^ (base[CRC_W-1] ? POLY : '0);
      end

      AST_ZERO_KEPT_DIV: assert property (@(posedge clk) disable iff (!rstN)
        (strb.shift && !strb.start && crcReg == '0 && !dIn) |=> (crcReg == '0)); // R6
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '0;
    end else if (strb.shift) begin
      crcReg <= crcNxt;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(crcReg)); // R9

endmodule

// File: rtl/crc32_serial_gen.sv
module crc32_serial_gen
  import crc32_pkg::*;
#(
  parameter crcArch_e         ARCH  = ARCH_SMD,
  parameter int               CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic             sofIn,
  input  logic             eofIn,
  output logic [CRC_W-1:0] fcsOut,
  output logic             fcsDone
);

  crcStrb_t         strb;
  logic [CRC_W-1:0] crcReg;

  crc32_ctrl #(
    .ARCH  (ARCH),
    .CRC_W (CRC_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .sofIn    (sofIn),
    .eofIn    (eofIn),
    .strb     (strb),
    .fcsDone  (fcsDone)
  );

  crc32_dp #(
    .ARCH  (ARCH),
    .CRC_W (CRC_W),
    .POLY  (POLY)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .bitIn  (bitIn),
    .strb   (strb),
    .crcReg (crcReg)
  );

  assign fcsOut = ~crcReg;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !fcsDone); // R1

endmodule

// File: tb/sim_crc32_serial_gen.sv
module sim_crc32_serial_gen;
  import crc32_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_BITS   = 2048;

  logic clk = 1'b0, rstN = 1'b0;
  logic bitValid = 1'b0, bitIn = 1'b0, sofIn = 1'b0, eofIn = 1'b0;
  logic [31:0] fcsA, fcsB;
  logic doneA, doneB;

  crc32_serial_gen #(.ARCH(ARCH_SMD)) u0 (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .sofIn(sofIn), .eofIn(eofIn), .fcsOut(fcsA), .fcsDone(doneA));

  crc32_serial_gen #(.ARCH(ARCH_DIV)) u1 (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .sofIn(sofIn), .eofIn(eofIn), .fcsOut(fcsB), .fcsDone(doneB));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;
  bit gotA, gotB;
  logic [31:0] capA, capB;
  int cycA, cycB, eofCyc;
  logic frmBits [0:MAX_BITS-1];
  int nBits;
  logic [31:0] seed = 32'h1234_5678;

  always @(negedge clk) begin
    if (doneA) begin gotA = 1'b1; capA = fcsA; cycA = cycle; end
    if (doneB) begin gotB = 1'b1; capB = fcsB; cycB = cycle; end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic clearFrame();
    nBits = 0;
  endtask

  task automatic pushBit(input logic b);
    frmBits[nBits] = b;
    nBits++;
  endtask

  task automatic pushByte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) pushBit(b[k]);
  endtask

  function automatic logic [7:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  // Reflected bit-serial reference, result bit-reversed so bit 31 goes first
  function automatic logic [31:0] refFcs();
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] r;
    for (int i = 0; i < nBits; i++) begin
      if (c[0] ^ frmBits[i]) c = (c >> 1) ^ 32'hEDB8_8320;
      else                   c = c >> 1;
    end
    c = ~c;
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return r;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic driveFrame(input int gap, input bit withEof);
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk);
      bitValid = 1'b1;
      bitIn    = frmBits[i];
      sofIn    = (i == 0);
      eofIn    = withEof && (i == nBits - 1);
      if (eofIn) eofCyc = cycle + 1;
      if (gap > 0 && (i % gap) == gap - 1 && i != nBits - 1) begin
        @(negedge clk);
        bitValid = 1'b0;  // strobes with valid low must be ignored (R9)
        bitIn    = ~bitIn;
        sofIn    = 1'b1;
        eofIn    = 1'b1;
      end
    end
    @(negedge clk);
    bitValid = 1'b0; bitIn = 1'b0; sofIn = 1'b0; eofIn = 1'b0;
  endtask

  task automatic runFrame(input string tag, input int gap);
    logic [31:0] exp;
    exp  = refFcs();
    gotA = 1'b0; gotB = 1'b0;
    driveFrame(gap, 1'b1);
    idle(40);
    check({tag, " R2 smd done seen"}, 32'(gotA), 32'd1);
    check({tag, " R2 smd fcs"}, capA, exp);
    check({tag, " R5 div fcs"}, capB, exp);
    check({tag, " R3 smd latency"}, 32'(cycA - eofCyc), 32'd0);
    check({tag, " R4 div latency"}, 32'(cycB - eofCyc), 32'd32);
  endtask

  task automatic testReset();
    check("R1 smd done in reset", 32'(doneA), 32'd0);
    check("R1 div fcs in reset", fcsB, 32'hFFFF_FFFF);
    @(negedge clk) rstN = 1'b1;
    idle(2);
    check("R1 smd fcs after reset", fcsA, 32'hFFFF_FFFF);
    check("R1 div fcs after reset", fcsB, 32'hFFFF_FFFF);
    check("R1 div done after reset", 32'(doneB), 32'd0);
  endtask

  task automatic testKnownVector();
    clearFrame();
    for (int d = 8'h31; d <= 8'h39; d++) pushByte(8'(d));
    check("R2 reference model vector", refFcs(), 32'h649C_2FD3);
    runFrame("digits", 0);
    check("R2 smd digits constant", capA, 32'h649C_2FD3);
  endtask

  task automatic testRandomFrames();
    int lens [3] = '{5, 46, 64};
    for (int f = 0; f < 3; f++) begin
      clearFrame();
      for (int b = 0; b < lens[f]; b++) pushByte(nextRand());
      runFrame($sformatf("rand%0d", lens[f]), 0);
    end
  endtask

  task automatic testShortFrames();
    int lens [6] = '{1, 8, 31, 32, 33, 77};
    for (int f = 0; f < 6; f++) begin
      clearFrame();
      for (int b = 0; b < lens[f]; b++) pushBit(nextRand() > 8'd100);
      // lens 1 is a single bit with sof and eof together (R11)
      runFrame($sformatf("R11/R5 bits%0d", lens[f]), 0);
    end
  endtask

  task automatic testZeroState();
    clearFrame();
    repeat (4) pushByte(8'hFF);
    runFrame("R6 four ones", 0);
    check("R6 smd all-ones frame", capA, 32'hFFFF_FFFF);
    check("R6 div all-ones frame", capB, 32'hFFFF_FFFF);
    clearFrame();
    repeat (4) pushByte(8'hFF);
    pushByte(8'h12); pushByte(8'h34); pushByte(8'h00);
    runFrame("R6 through zero", 0);
  endtask

  task automatic testResidue();
    logic [31:0] f;
    clearFrame();
    for (int b = 0; b < 20; b++) pushByte(nextRand());
    f = refFcs();
    for (int k = 31; k >= 0; k--) pushBit(f[k]);
    runFrame("R7 residue", 0);
    check("R7 smd residue", capA, 32'h38FB_2284);
    check("R7 div residue", capB, 32'h38FB_2284);
  endtask

  task automatic testRestart();
    clearFrame();
    for (int b = 0; b < 23; b++) pushBit(1'b1);
    driveFrame(0, 1'b0);  // unfinished frame
    clearFrame();
    for (int b = 0; b < 9; b++) pushByte(nextRand());
    runFrame("R8 restart", 0);
  endtask

  task automatic testGapsAndStray();
    logic [31:0] holdA, holdB;
    clearFrame();
    for (int b = 0; b < 12; b++) pushByte(nextRand());
    runFrame("R9 gaps", 3);
    holdA = fcsA; holdB = fcsB;
    gotA = 1'b0; gotB = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bitValid = 1'b1; sofIn = 1'b0; eofIn = 1'b1; bitIn = i[0];
    end
    @(negedge clk);
    bitValid = 1'b0; eofIn = 1'b0; bitIn = 1'b0;
    idle(40);
    check("R9 smd fcs unchanged by stray bits", fcsA, holdA);
    check("R9 div fcs unchanged by stray bits", fcsB, holdB);
    check("R9 no done from stray bits", 32'(gotA | gotB), 32'd0);
  endtask

  task automatic testFlushIgnore();
    logic [31:0] exp;
    clearFrame();
    for (int b = 0; b < 6; b++) pushByte(nextRand());
    exp  = refFcs();
    gotA = 1'b0; gotB = 1'b0;
    driveFrame(0, 1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      bitValid = 1'b1; sofIn = (i % 3 == 0); eofIn = 1'b0; bitIn = nextRand() > 8'd90;
    end
    @(negedge clk);
    bitValid = 1'b0; sofIn = 1'b0; bitIn = 1'b0;
    idle(40);
    check("R10 div fcs with flush-time input", capB, exp);
    check("R10 div latency with flush-time input", 32'(cycB - eofCyc), 32'd32);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  initial begin
    idle(3);
    testReset();
    testKnownVector();
    testRandomFrames();
    testShortFrames();
    testZeroState();
    testResidue();
    testRestart();
    testGapsAndStray();
    testFlushIgnore();
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule